// File: doc/BRIEF.md
# Embedded Sync Code Decoder

This block recovers line, blanking and field timing from timing reference codes carried inside a multiplexed YCbCr word stream. It sits after the capture and demultiplexing logic. For each accepted word it receives the captured byte and the slot that byte holds in the repeating Cb, Y, Cr, Y sequence. A code is a three-word preamble followed by a status word. The status word gives the field, the blanking state, and whether the code marks the start or the end of active video.

The decoder produces one-cycle start-of-active and end-of-active pulses. It also produces registered field, vertical-blanking and line-sync flags. A select input routes either these decoded signals or the dedicated H and V pins to the block's sync outputs. Decoding, and the route to decoded timing, are active only while the input format selector holds the YCbCr code.

Top module: `esd_top`

## Requirements
- R1: While reset is asserted, and after it is released, sav_o, eav_o, f_o, v_o and h_o are all 0.
- R2: A code is the words FFh, 00h, 00h on three consecutive accepted words (word_valid_i high), followed by a fourth accepted word taken as the status byte. One cycle after the status word is accepted, sav_o pulses if status bit 4 is 0, or eav_o pulses if status bit 4 is 1.
- R3: A preamble is recognised only if its FFh word arrives with phase_i = 0 (the Cb slot; 1 = first Y, 2 = Cr, 3 = second Y). A preamble that starts in any other slot produces no pulse and leaves every flag unchanged.
- R4: f_o takes status bit 6 (1 = second field, 0 = first field) when a code is decoded, and holds it otherwise.
- R5: v_o takes status bit 5 (1 = field blanking) when a code is decoded, and holds it otherwise.
- R6: h_o is set by an end-of-active code and stays set until the next start-of-active code clears it.
- R7: A broken preamble (for example FFh, 00h, then a non-zero word) produces no pulse and leaves the flags unchanged.
- R8: When fmt_i is not 4, no code is decoded, and the flags hold their values.
- R9: hsync_o and vsync_o equal h_o and v_o when sync_sel_i is 1 and fmt_i is 4. Otherwise they equal hpin_i and vpin_i.
- R10: sav_o and eav_o are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Captured word present this cycle |
| word_i | input | 8 | Captured data word |
| phase_i | input | 2 | Slot of word: 0 Cb, 1 Y, 2 Cr, 3 Y |
| fmt_i | input | 3 | Input format selector; 4 = YCbCr |
| sync_sel_i | input | 1 | 1 = decoded timing, 0 = pins |
| hpin_i | input | 1 | External horizontal sync pin |
| vpin_i | input | 1 | External vertical sync pin |
| sav_o | output | 1 | Start-of-active-video pulse |
| eav_o | output | 1 | End-of-active-video pulse |
| f_o | output | 1 | Decoded field flag |
| v_o | output | 1 | Decoded vertical blanking flag |
| h_o | output | 1 | Decoded line sync (EAV to SAV) |
| hsync_o | output | 1 | Selected horizontal sync |
| vsync_o | output | 1 | Selected vertical sync |

## Verification
The assertions assume that pulses come only from a complete four-word code. They also assume that the flags change only together with a pulse, so no code-like pattern may arise by chance in ordinary data. The stimulus uses only payload values, such as 10h and 80h, that cannot form an FFh, 00h, 00h run. The stimulus sends each word with word_valid_i high for a single cycle and leaves idle cycles between words. It changes fmt_i and sync_sel_i only between codes, never partway through a preamble.

// File: rtl/esd_pkg.sv
package esd_pkg;
  localparam int unsigned PRE_LEN = 3;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } esd_flags_t;
endpackage

// File: rtl/esd_preamble_det.sv
module esd_preamble_det #(
  parameter int unsigned DW       = 8,
  parameter int unsigned PH_W     = 2,
  parameter int unsigned FMT_W    = 3,
  parameter int unsigned FMT_YCC  = 4,
  parameter int unsigned CB_PHASE = 0,
  parameter int unsigned F_BIT    = 6,
  parameter int unsigned V_BIT    = 5,
  parameter int unsigned H_BIT    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [DW-1:0]       word_i,
  input  logic [PH_W-1:0]     phase_i,
  input  logic [FMT_W-1:0]    fmt_i,
  output logic                en_o,
  output logic                hit_o,
  output esd_pkg::esd_flags_t flags_o
);
  localparam int unsigned PRE_LEN = esd_pkg::PRE_LEN;
  localparam int unsigned CNT_W   = $clog2(PRE_LEN + 1);

  logic [CNT_W-1:0] stage_q, stage_d;
  logic lead;

  assign en_o = (fmt_i == FMT_YCC[FMT_W-1:0]);
  // preamble must open on a Cb slot
  assign lead = (word_i == {DW{1'b1}}) && (phase_i == CB_PHASE[PH_W-1:0]);

  always_comb begin
    stage_d = stage_q;
    hit_o   = 1'b0;
    if (!en_o) begin
      stage_d = '0;
    end else if (valid_i) begin
      if (stage_q == CNT_W'(PRE_LEN)) begin
        hit_o   = 1'b1;
        stage_d = '0;
      end else if (stage_q != '0 && word_i == '0) begin
        stage_d = stage_q + CNT_W'(1);
      end else begin
        stage_d = lead ? CNT_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign flags_o = '{f: word_i[F_BIT], v: word_i[V_BIT], h: word_i[H_BIT]};

  a_r8_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> (stage_q == '0));
  a_r2_hit_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (valid_i && en_o));
endmodule

// File: rtl/esd_flag_reg.sv
module esd_flag_reg (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_i,
  input  esd_pkg::esd_flags_t flags_i,
  output logic                sav_o,
  output logic                eav_o,
  output logic                f_o,
  output logic                v_o,
  output logic                h_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sav_o <= 1'b0;
      eav_o <= 1'b0;
      f_o   <= 1'b0;
      v_o   <= 1'b0;
      h_o   <= 1'b0;
    end else begin
      sav_o <= hit_i && !flags_i.h;
      eav_o <= hit_i &&  flags_i.h;
      if (hit_i) begin
        f_o <= flags_i.f;
        v_o <= flags_i.v;
        h_o <= flags_i.h;   // EAV sets, SAV clears
      end
    end
  end

  a_r10_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sav_o && eav_o));
  a_r10_sav_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sav_o |=> !sav_o);
  a_r10_eav_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_o |=> !eav_o);
  a_r4_f_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sav_o && !eav_o) |-> $stable(f_o));
  a_r5_v_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sav_o && !eav_o) |-> $stable(v_o));
  a_r6_h_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sav_o && !eav_o) |-> $stable(h_o));
endmodule

// File: rtl/esd_sync_sel.sv
module esd_sync_sel #(
  parameter int unsigned N = 2
) (
  input  logic         use_emb_i,
  input  logic [N-1:0] emb_i,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] out_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign out_o[i] = use_emb_i ? emb_i[i] : pin_i[i];
  end
endmodule

// File: rtl/esd_top.sv
module esd_top #(
  parameter int unsigned DW      = 8,
  parameter int unsigned PH_W    = 2,
  parameter int unsigned FMT_W   = 3,
  parameter int unsigned FMT_YCC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_valid_i,
  input  logic [DW-1:0]    word_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [FMT_W-1:0] fmt_i,
  input  logic             sync_sel_i,
  input  logic             hpin_i,
  input  logic             vpin_i,
  output logic             sav_o,
  output logic             eav_o,
  output logic             f_o,
  output logic             v_o,
  output logic             h_o,
  output logic             hsync_o,
  output logic             vsync_o
);
  logic en, hit;
  esd_pkg::esd_flags_t flags;
  logic [1:0] sel_out;

  esd_preamble_det #(
    .DW(DW), .PH_W(PH_W), .FMT_W(FMT_W), .FMT_YCC(FMT_YCC),
    .CB_PHASE(0), .F_BIT(6), .V_BIT(5), .H_BIT(4)
  ) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(word_valid_i), .word_i(word_i),
    .phase_i(phase_i), .fmt_i(fmt_i), .en_o(en), .hit_o(hit), .flags_o(flags)
  );

  esd_flag_reg u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .flags_i(flags),
    .sav_o(sav_o), .eav_o(eav_o), .f_o(f_o), .v_o(v_o), .h_o(h_o)
  );

  esd_sync_sel #(.N(2)) u_sel (
    .use_emb_i(sync_sel_i && en), .emb_i({v_o, h_o}),
    .pin_i({vpin_i, hpin_i}), .out_o(sel_out)
  );

  assign hsync_o = sel_out[0];
  assign vsync_o = sel_out[1];

  a_r8_no_pulse_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i != FMT_YCC[FMT_W-1:0]) |=> (!sav_o && !eav_o));
  a_r2_pulse_from_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sav_o || eav_o) |-> $past(word_valid_i));
endmodule

// File: tb/esd_top_test.sv
module esd_top_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic valid = 0, sel = 0, hpin = 0, vpin = 0;
  logic [7:0] word = 0;
  logic [1:0] phase = 0;
  logic [2:0] fmt = 3'd4;
  logic sav, eav, f, v, h, hs, vs;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  esd_top uut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(valid), .word_i(word),
    .phase_i(phase), .fmt_i(fmt), .sync_sel_i(sel), .hpin_i(hpin), .vpin_i(vpin),
    .sav_o(sav), .eav_o(eav), .f_o(f), .v_o(v), .h_o(h),
    .hsync_o(hs), .vsync_o(vs)
  );

  task automatic chk(input string name, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", name, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] w, input logic [1:0] ph);
    @(negedge clk);
    word = w; phase = ph; valid = 1;
    @(posedge clk);
    @(negedge clk);
    valid = 0;
  endtask

  // after return: at the negedge following the status-word edge
  task automatic send_code(input logic [7:0] st, input logic [1:0] lp);
    send(8'hFF, lp);
    send(8'h00, lp + 2'd1);
    send(8'h00, lp + 2'd2);
    send(st,    lp + 2'd3);
  endtask

  task automatic t_reset;
    chk("R1 sav", sav, 0); chk("R1 eav", eav, 0);
    chk("R1 f", f, 0); chk("R1 v", v, 0); chk("R1 h", h, 0);
  endtask

  task automatic t_sav_eav;
    send_code(8'h80, 2'd0);
    chk("R2 sav pulse", sav, 1); chk("R2 no eav", eav, 0);
    @(negedge clk);
    chk("R10 sav one cycle", sav, 0);
    send_code(8'h90, 2'd0);
    chk("R2 eav pulse", eav, 1); chk("R10 excl", sav, 0);
    chk("R6 h set by eav", h, 1);
    @(negedge clk);
    chk("R10 eav one cycle", eav, 0);
    send(8'h10, 2'd0); send(8'h80, 2'd1);
    chk("R6 h held", h, 1);
    send_code(8'h80, 2'd0);
    chk("R6 h cleared by sav", h, 0);
  endtask

  task automatic t_fv;
    send_code(8'hF0, 2'd0);
    chk("R4 f=1", f, 1); chk("R5 v=1", v, 1); chk("R2 eav", eav, 1);
    send_code(8'hA0, 2'd0);
    chk("R4 f=0", f, 0); chk("R5 v held 1", v, 1); chk("R2 sav", sav, 1);
    send_code(8'hC0, 2'd0);
    chk("R4 f=1 again", f, 1); chk("R5 v=0", v, 0);
  endtask

  task automatic t_phase;
    // f=1,v=0,h=0 now
    for (int lp = 1; lp < 4; lp++) begin
      send_code(8'hB0, 2'(lp));
      chk("R3 no eav off-Cb", eav, 0); chk("R3 no sav off-Cb", sav, 0);
      chk("R3 v unchanged", v, 0); chk("R3 f unchanged", f, 1);
    end
  endtask

  task automatic t_broken;
    send(8'hFF, 2'd0); send(8'h00, 2'd1); send(8'h12, 2'd2); send(8'hB0, 2'd3);
    chk("R7 no eav", eav, 0); chk("R7 h unchanged", h, 0);
    chk("R7 v unchanged", v, 0);
    send_code(8'h90, 2'd0);
    chk("R7 recovers", eav, 1);
  endtask

  task automatic t_fmt;
    // f=0,v=0,h=1 now
    fmt = 3'd1;
    send_code(8'hE0, 2'd0);
    chk("R8 no sav", sav, 0); chk("R8 f held", f, 0);
    chk("R8 v held", v, 0); chk("R8 h held", h, 1);
    fmt = 3'd4;
  endtask

  task automatic t_mux;
    // h=1, v=0
    sel = 0; hpin = 0; vpin = 1;
    @(negedge clk);
    chk("R9 pin h", hs, 0); chk("R9 pin v", vs, 1);
    sel = 1;
    @(negedge clk);
    chk("R9 emb h", hs, 1); chk("R9 emb v", vs, 0);
    fmt = 3'd0;
    @(negedge clk);
    chk("R9 fmt forces pin h", hs, 0); chk("R9 fmt forces pin v", vs, 1);
    fmt = 3'd4; sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_sav_eav;
    t_fv;
    t_phase;
    t_broken;
    t_fmt;
    t_mux;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule